// File: doc/BRIEF.md
# DRAM activity thermal throttle

This block estimates how much energy each row (or rank) of a memory interface is drawing and holds back traffic to any row that draws too much. Each completed access reports its row index, the number of 16-word transfer units it moved, and whether it was a page hit, a page miss or a page empty cycle. The block turns every access into a weighted activity increment (programmable weight for the cycle type times the transfer count). It adds that increment into a private accumulator for the addressed row.

Time is cut into monitoring windows of programmable length. At the end of each window every row's total is compared with a programmable limit. A row whose total went over the limit is marked as throttled for the whole of the next window, and all accumulators restart from zero. While a row is throttled, its command-permission output follows a duty pattern: commands are allowed in only the first N cycles of every M-cycle period. An external over-temperature input throttles every row at once. A per-row sticky flag records that throttling happened, and software clears it by writing ones.

Top module: `dram_thermal_throttle`

## Requirements
- R1: An access with `ev_valid` high adds weight × `ev_xfers` to its row's accumulator, where the weight is chosen by `ev_kind`: 0 = page hit (`cfg_wgt_hit`), 1 = page miss (`cfg_wgt_miss`), 2 = page empty (`cfg_wgt_empty`); code 3 adds nothing.
- R2: Each row has its own accumulator and verdict; an access to one row never changes the throttle state of another row.
- R3: A window lasts `cfg_win_len` cycles (0 behaves as 1). Accumulators are zero at the start of each window, totals do not carry across windows, and an access in the last cycle of a window counts toward that window.
- R4: At each window end a row becomes throttled for the following window if its total is strictly greater than the limit, and is released otherwise. Between window ends the verdict does not change.
- R5: Accumulators saturate at their all-ones value and never wrap.
- R6: Weights, limit and window length are sampled only at a window end (and in the first cycle after reset). A change made during a window has no effect on that window's verdict.
- R7: While `overtemp` is high, all bits of `throttle` are high in the same cycle, whatever the totals are.
- R8: For a throttled row, `cmd_ok` is high in exactly the first `cfg_duty_on` cycles of every `cfg_duty_period`-cycle period (period 0 behaves as 1; a free-running phase counter). An unthrottled row has `cmd_ok` high every cycle.
- R9: `sticky[i]` is set in the cycle after `throttle[i]` is high. It is cleared by a cycle with `sticky_clr[i]` high. A new set in the same cycle takes priority over the clear.
- R10: Reset (`rst_n` low, asynchronous) leaves no row throttled, no sticky bit set, and with `overtemp` low every `cmd_ok` bit high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | A completed access is reported this cycle |
| ev_row | input | ROW_W | Row index of the access |
| ev_xfers | input | XFER_W | Transfer units (16-word) moved by the access |
| ev_kind | input | 2 | Cycle type: 0 hit, 1 miss, 2 empty, 3 no weight |
| cfg_wgt_hit | input | WGT_W | Weight of a page-hit transfer |
| cfg_wgt_miss | input | WGT_W | Weight of a page-miss transfer |
| cfg_wgt_empty | input | WGT_W | Weight of a page-empty transfer |
| cfg_limit | input | ACC_W | Activity limit per window |
| cfg_win_len | input | WIN_W | Window length in cycles |
| cfg_duty_on | input | DUTY_W | Allowed cycles per duty period when throttled |
| cfg_duty_period | input | DUTY_W | Duty period length in cycles |
| overtemp | input | 1 | Forces throttling of every row |
| sticky_clr | input | ROWS | Write-one-to-clear for the sticky flags |
| throttle | output | ROWS | Row is throttled |
| cmd_ok | output | ROWS | A command to the row may issue this cycle |
| sticky | output | ROWS | Row has been throttled since last clear |

## Verification
Two functions can land in the same cycle: an access can arrive in the very cycle a window closes, and a sticky bit can be set while software writes a one to clear it. The bench drives an access exactly in the cycle its own window model marks as final. It then expects the throttle for that row after the boundary, proving the increment was folded into the closing total and not into the fresh window. It also raises `overtemp` together with a full `sticky_clr` and expects every sticky bit still set one cycle later. A cycle-level model in the bench, built from the requirements, cross-checks `throttle`, `cmd_ok` and `sticky` on every cycle of the sweeps.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
  typedef enum logic [1:0] {
    KIND_HIT   = 2'd0,
    KIND_MISS  = 2'd1,
    KIND_EMPTY = 2'd2,
    KIND_NONE  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/thr_window_timer.sv
`timescale 1ns/1ps
// Window counter plus the configuration shadow that is refreshed at each window end.
module thr_window_timer #(
  parameter int WIN_W = 16,
  parameter int WGT_W = 4,
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] cfg_win_len,
  input  logic [WGT_W-1:0] cfg_wgt_hit,
  input  logic [WGT_W-1:0] cfg_wgt_miss,
  input  logic [WGT_W-1:0] cfg_wgt_empty,
  input  logic [ACC_W-1:0] cfg_limit,
  output logic             win_end,
  output logic             primed,
  output logic [WGT_W-1:0] wgt_hit,
  output logic [WGT_W-1:0] wgt_miss,
  output logic [WGT_W-1:0] wgt_empty,
  output logic [ACC_W-1:0] limit
);
  logic [WIN_W-1:0] len_q;
  logic [WIN_W-1:0] cnt_q;

  // Index of the final cycle of a window; length 0 acts as length 1.
  function automatic logic [WIN_W-1:0] last_tick(input logic [WIN_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  assign win_end = !primed || (cnt_q == last_tick(len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      cnt_q     <= '0;
      primed    <= 1'b0;
      wgt_hit   <= '0;
      wgt_miss  <= '0;
      wgt_empty <= '0;
      limit     <= '0;
    end else if (win_end) begin
      cnt_q     <= '0;
      primed    <= 1'b1;
      len_q     <= cfg_win_len;
      wgt_hit   <= cfg_wgt_hit;
      wgt_miss  <= cfg_wgt_miss;
      wgt_empty <= cfg_wgt_empty;
      limit     <= cfg_limit;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/thr_row_acc.sv
`timescale 1ns/1ps
// One row: saturating activity total, window verdict, throttle and sticky flag.
module thr_row_acc #(
  parameter int ACC_W = 12,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [INC_W-1:0] inc,
  input  logic             win_end,
  input  logic             primed,
  input  logic [ACC_W-1:0] limit,
  input  logic             force_on,
  input  logic             clr,
  output logic [ACC_W-1:0] acc_q,
  output logic             over_q,
  output logic             throttle,
  output logic             sticky
);
  localparam int SUM_W = ((ACC_W > INC_W) ? ACC_W : INC_W) + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b);
    return (s > SUM_W'(ACC_MAX)) ? ACC_MAX : s[ACC_W-1:0];
  endfunction

  logic [ACC_W-1:0] acc_sum;
  assign acc_sum  = hit ? sat_add(acc_q, inc) : acc_q;
  assign throttle = over_q | force_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      over_q <= 1'b0;
    end else if (win_end) begin
      acc_q  <= '0;
      over_q <= primed && (acc_sum > limit);
    end else begin
      acc_q  <= acc_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= 1'b0;
    else        sticky <= (sticky & ~clr) | throttle;
  end
endmodule

// File: rtl/thr_duty_gate.sv
`timescale 1ns/1ps
// Free-running duty phase; throttled rows may issue only in the leading slots.
module thr_duty_gate #(
  parameter int ROWS   = 4,
  parameter int DUTY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_on,
  input  logic [DUTY_W-1:0] duty_period,
  input  logic [ROWS-1:0]   throttle,
  output logic              in_slot,
  output logic [ROWS-1:0]   cmd_ok
);
  logic [DUTY_W-1:0] phase_q;

  function automatic logic [DUTY_W-1:0] last_phase(input logic [DUTY_W-1:0] per);
    return (per == '0) ? '0 : per - 1'b1;
  endfunction

  assign in_slot = (phase_q < duty_on);
  assign cmd_ok  = ~throttle | {ROWS{in_slot}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               phase_q <= '0;
    else if (phase_q >= last_phase(duty_period)) phase_q <= '0;
    else                                      phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/dram_thermal_throttle.sv
`timescale 1ns/1ps
module dram_thermal_throttle #(
  parameter int ROWS   = 4,
  parameter int ACC_W  = 12,
  parameter int WIN_W  = 16,
  parameter int XFER_W = 4,
  parameter int WGT_W  = 4,
  parameter int DUTY_W = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [XFER_W-1:0] ev_xfers,
  input  logic [1:0]        ev_kind,
  input  logic [WGT_W-1:0]  cfg_wgt_hit,
  input  logic [WGT_W-1:0]  cfg_wgt_miss,
  input  logic [WGT_W-1:0]  cfg_wgt_empty,
  input  logic [ACC_W-1:0]  cfg_limit,
  input  logic [WIN_W-1:0]  cfg_win_len,
  input  logic [DUTY_W-1:0] cfg_duty_on,
  input  logic [DUTY_W-1:0] cfg_duty_period,
  input  logic              overtemp,
  input  logic [ROWS-1:0]   sticky_clr,
  output logic [ROWS-1:0]   throttle,
  output logic [ROWS-1:0]   cmd_ok,
  output logic [ROWS-1:0]   sticky
);
  import thr_pkg::*;

  localparam int INC_W = WGT_W + XFER_W;

  // Named internal events, brought out for the checker.
  logic                  win_end;
  logic                  primed;
  logic                  in_slot;
  logic [ROWS-1:0]       row_over;
  logic [ROWS*ACC_W-1:0] acc_flat;

  logic [WGT_W-1:0] wgt_hit, wgt_miss, wgt_empty;
  logic [ACC_W-1:0] limit;
  logic [WGT_W-1:0] wgt_sel;
  logic [INC_W-1:0] inc;

  function automatic logic [WGT_W-1:0] pick_weight(input acc_kind_e k,
                                                   input logic [WGT_W-1:0] wh,
                                                   input logic [WGT_W-1:0] wm,
                                                   input logic [WGT_W-1:0] we);
    case (k)
      KIND_HIT:   return wh;
      KIND_MISS:  return wm;
      KIND_EMPTY: return we;
      default:    return '0;
    endcase
  endfunction

  assign wgt_sel = pick_weight(acc_kind_e'(ev_kind), wgt_hit, wgt_miss, wgt_empty);
  assign inc     = INC_W'(wgt_sel) * INC_W'(ev_xfers);

  thr_window_timer #(.WIN_W(WIN_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_win_len  (cfg_win_len),
    .cfg_wgt_hit  (cfg_wgt_hit),
    .cfg_wgt_miss (cfg_wgt_miss),
    .cfg_wgt_empty(cfg_wgt_empty),
    .cfg_limit    (cfg_limit),
    .win_end      (win_end),
    .primed       (primed),
    .wgt_hit      (wgt_hit),
    .wgt_miss     (wgt_miss),
    .wgt_empty    (wgt_empty),
    .limit        (limit)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic row_hit;
    assign row_hit = ev_valid && (ev_row == ROW_W'(g));

    thr_row_acc #(.ACC_W(ACC_W), .INC_W(INC_W)) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (row_hit),
      .inc     (inc),
      .win_end (win_end),
      .primed  (primed),
      .limit   (limit),
      .force_on(overtemp),
      .clr     (sticky_clr[g]),
      .acc_q   (acc_flat[g*ACC_W +: ACC_W]),
      .over_q  (row_over[g]),
      .throttle(throttle[g]),
      .sticky  (sticky[g])
    );
  end

  thr_duty_gate #(.ROWS(ROWS), .DUTY_W(DUTY_W)) u_duty (
    .clk        (clk),
    .rst_n      (rst_n),
    .duty_on    (cfg_duty_on),
    .duty_period(cfg_duty_period),
    .throttle   (throttle),
    .in_slot    (in_slot),
    .cmd_ok     (cmd_ok)
  );
endmodule

// File: rtl/thr_checker.sv
`timescale 1ns/1ps
module thr_checker #(
  parameter int ROWS  = 4,
  parameter int ACC_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  overtemp,
  input logic [ROWS-1:0]       throttle,
  input logic [ROWS-1:0]       cmd_ok,
  input logic [ROWS-1:0]       sticky,
  input logic [ROWS-1:0]       sticky_clr,
  input logic                  win_end,
  input logic [ROWS-1:0]       row_over,
  input logic [ROWS*ACC_W-1:0] acc_flat
);
  AST_OVERTEMP_ALL_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |-> (&throttle)); // R7

  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(row_over)); // R4

  AST_WINDOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (acc_flat == '0)); // R3

  AST_STICKY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (|throttle) |=> ((sticky & $past(throttle)) == $past(throttle))); // R9

  AST_STICKY_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sticky) & ~sticky) & ~$past(sticky_clr)) == '0)); // R9

  AST_FREE_ROWS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!overtemp && (row_over == '0)) |-> (&cmd_ok)); // R8

  for (genvar g = 0; g < ROWS; g++) begin : g_acc
    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> (acc_flat[g*ACC_W +: ACC_W] >= $past(acc_flat[g*ACC_W +: ACC_W]))); // R5
  end
endmodule

bind dram_thermal_throttle thr_checker #(.ROWS(ROWS), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .overtemp  (overtemp),
  .throttle  (throttle),
  .cmd_ok    (cmd_ok),
  .sticky    (sticky),
  .sticky_clr(sticky_clr),
  .win_end   (win_end),
  .row_over  (row_over),
  .acc_flat  (acc_flat)
);

// File: tb/dram_thermal_throttle_tb.sv
`timescale 1ns/1ps
module dram_thermal_throttle_tb;
  localparam int ROWS = 4, ACC_W = 8, WIN_W = 8, XFER_W = 4, WGT_W = 4, DUTY_W = 4;
  localparam int ACC_MAX = 255;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_valid;
  logic [1:0] ev_row;
  logic [XFER_W-1:0] ev_xfers;
  logic [1:0] ev_kind;
  logic [WGT_W-1:0] cfg_wgt_hit, cfg_wgt_miss, cfg_wgt_empty;
  logic [ACC_W-1:0] cfg_limit;
  logic [WIN_W-1:0] cfg_win_len;
  logic [DUTY_W-1:0] cfg_duty_on, cfg_duty_period;
  logic overtemp;
  logic [ROWS-1:0] sticky_clr;
  logic [ROWS-1:0] throttle, cmd_ok, sticky;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dram_thermal_throttle #(.ROWS(ROWS), .ACC_W(ACC_W), .WIN_W(WIN_W), .XFER_W(XFER_W),
                          .WGT_W(WGT_W), .DUTY_W(DUTY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_row(ev_row), .ev_xfers(ev_xfers),
    .ev_kind(ev_kind), .cfg_wgt_hit(cfg_wgt_hit), .cfg_wgt_miss(cfg_wgt_miss),
    .cfg_wgt_empty(cfg_wgt_empty), .cfg_limit(cfg_limit), .cfg_win_len(cfg_win_len),
    .cfg_duty_on(cfg_duty_on), .cfg_duty_period(cfg_duty_period), .overtemp(overtemp),
    .sticky_clr(sticky_clr), .throttle(throttle), .cmd_ok(cmd_ok), .sticky(sticky)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench model written from the requirements.
  int m_acc [ROWS];
  bit m_over [ROWS];
  bit m_primed;
  int m_wc, m_len, m_thr, m_wh, m_wm, m_we, m_pc;
  bit [ROWS-1:0] m_sticky;

  function automatic bit pending();
    return !m_primed || (m_wc == ((m_len == 0) ? 0 : m_len - 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin m_acc[r] = 0; m_over[r] = 0; end
      m_primed = 0; m_wc = 0; m_len = 0; m_thr = 0;
      m_wh = 0; m_wm = 0; m_we = 0; m_pc = 0; m_sticky = '0;
    end else begin
      bit bnd;
      int w;
      int per;
      bit [ROWS-1:0] t_now;
      for (int r = 0; r < ROWS; r++) t_now[r] = m_over[r] | overtemp;
      m_sticky = (m_sticky & ~sticky_clr) | t_now;
      bnd = pending();
      for (int r = 0; r < ROWS; r++) begin
        if (ev_valid && (int'(ev_row) == r)) begin
          w = (ev_kind == 2'd0) ? m_wh : (ev_kind == 2'd1) ? m_wm : (ev_kind == 2'd2) ? m_we : 0;
          m_acc[r] = m_acc[r] + w * int'(ev_xfers);
          if (m_acc[r] > ACC_MAX) m_acc[r] = ACC_MAX;
        end
      end
      if (bnd) begin
        for (int r = 0; r < ROWS; r++) begin
          m_over[r] = m_primed && (m_acc[r] > m_thr);
          m_acc[r]  = 0;
        end
        m_wc = 0; m_primed = 1;
        m_len = int'(cfg_win_len); m_thr = int'(cfg_limit);
        m_wh = int'(cfg_wgt_hit); m_wm = int'(cfg_wgt_miss); m_we = int'(cfg_wgt_empty);
      end else begin
        m_wc++;
      end
      per = (cfg_duty_period == 0) ? 1 : int'(cfg_duty_period);
      m_pc = (m_pc >= per - 1) ? 0 : m_pc + 1;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit [ROWS-1:0] e_thr, e_ok;
      for (int r = 0; r < ROWS; r++) e_thr[r] = m_over[r] | overtemp;
      e_ok = ~e_thr | ((m_pc < int'(cfg_duty_on)) ? {ROWS{1'b1}} : '0);
      chk("R4 throttle per cycle", int'(throttle), int'(e_thr));
      chk("R8 cmd_ok per cycle", int'(cmd_ok), int'(e_ok));
      chk("R9 sticky per cycle", int'(sticky), int'(m_sticky));
    end
  end

  task automatic wait_pending();
    while (!pending()) @(negedge clk);
  endtask

  task automatic to_next_window();
    wait_pending();
    @(negedge clk);
  endtask

  task automatic send(input int row, input int kind, input int xf);
    ev_valid = 1'b1; ev_row = 2'(row); ev_kind = 2'(kind); ev_xfers = 4'(xf);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (done) break;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int wt [4];
    int xs [3];
    int nlist [8];
    int mlist [8];
    wt[0] = 1; wt[1] = 3; wt[2] = 2; wt[3] = 0;
    xs[0] = 1; xs[1] = 5; xs[2] = 15;
    nlist = '{1, 2, 0, 7, 3, 0, 15, 4};
    mlist = '{3, 4, 5, 3, 0, 0, 15, 9};

    rst_n = 1'b0; ev_valid = 1'b0; ev_row = '0; ev_xfers = '0; ev_kind = '0;
    cfg_wgt_hit = 4'd1; cfg_wgt_miss = 4'd3; cfg_wgt_empty = 4'd2;
    cfg_limit = 8'd255; cfg_win_len = 8'd8; cfg_duty_on = 4'd2; cfg_duty_period = 4'd4;
    overtemp = 1'b0; sticky_clr = '0;

    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset throttle", int'(throttle), 0);
    chk("R10 reset sticky", int'(sticky), 0);
    chk("R10 reset cmd_ok", int'(cmd_ok), 15);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 after release throttle", int'(throttle), 0);

    // R1 / R2: each cycle type and transfer count, just under and at the limit.
    for (int k = 0; k < 4; k++) begin
      for (int xi = 0; xi < 3; xi++) begin
        for (int off = 0; off < 2; off++) begin
          int ex, th, row;
          ex  = wt[k] * xs[xi];
          th  = (ex == 0) ? off : ex - 1 + off;
          row = (k + xi) % ROWS;
          cfg_limit = 8'(th);
          to_next_window();
          send(row, k, xs[xi]);
          to_next_window(); #1;
          chk("R1 weighted total vs limit", int'(throttle[row]), (ex > th) ? 1 : 0);
          chk("R2 other rows untouched", int'(throttle & ~(4'b1 << row)), 0);
        end
      end
    end

    // R9: clear, and set winning over clear.
    to_next_window();
    sticky_clr = 4'hF; @(negedge clk); sticky_clr = '0; #1;
    chk("R9 write-one clears", int'(sticky), 0);
    overtemp = 1'b1; sticky_clr = 4'hF; #1;
    chk("R7 overtemp forces all", int'(throttle), 15);
    @(negedge clk); sticky_clr = '0; #1;
    chk("R9 set beats clear", int'(sticky), 15);

    // R8: duty pattern over whole periods while every row is forced.
    for (int p = 0; p < 8; p++) begin
      int me, cnt, ex;
      cfg_duty_on = 4'(nlist[p]); cfg_duty_period = 4'(mlist[p]);
      me = (mlist[p] == 0) ? 1 : mlist[p];
      repeat (20) @(negedge clk);
      cnt = 0;
      for (int c = 0; c < 3 * me; c++) begin
        #1; cnt += int'(cmd_ok[0]);
        @(negedge clk);
      end
      ex = 3 * ((nlist[p] < me) ? nlist[p] : me);
      chk("R8 allowed cycles per periods", cnt, ex);
    end
    overtemp = 1'b0;
    cfg_duty_on = 4'd1; cfg_duty_period = 4'd3; #1;
    chk("R8 free rows always allowed", int'(cmd_ok), 15);
    sticky_clr = 4'hF; @(negedge clk); sticky_clr = '0; #1;
    chk("R9 clear after overtemp", int'(sticky), 0);

    // R5: saturation instead of wrap (4 x 225 would wrap below 254).
    cfg_wgt_miss = 4'd15; cfg_limit = 8'd254;
    to_next_window();
    send(2, 1, 15);
    to_next_window(); #1;
    chk("R5 single access below limit", int'(throttle[2]), 0);
    for (int i = 0; i < 4; i++) send(2, 1, 15);
    to_next_window(); #1;
    chk("R5 saturated total above limit", int'(throttle[2]), 1);

    // R3: no carry across windows, boundary-cycle access, short window.
    cfg_win_len = 8'd4; cfg_limit = 8'd10;
    to_next_window();
    send(0, 0, 8);
    to_next_window();
    send(0, 0, 8);
    to_next_window(); #1;
    chk("R3 totals do not carry", int'(throttle[0]), 0);
    cfg_limit = 8'd5;
    to_next_window();
    wait_pending();
    send(1, 0, 8); #1;
    chk("R3 boundary-cycle access counts", int'(throttle[1]), 1);

    // R6 and R4: mid-window limit change, verdict held through the window.
    cfg_limit = 8'd100; cfg_win_len = 8'd8;
    to_next_window();
    to_next_window();
    send(3, 0, 8);
    cfg_limit = 8'd0;
    to_next_window(); #1;
    chk("R6 old limit judges window", int'(throttle[3]), 0);
    send(3, 0, 1);
    to_next_window(); #1;
    chk("R6 new limit after boundary", int'(throttle[3]), 1);
    repeat (3) @(negedge clk); #1;
    chk("R4 verdict held mid-window", int'(throttle[3]), 1);
    to_next_window(); #1;
    chk("R4 released after quiet window", int'(throttle[3]), 0);

    // R3: zero length behaves as one cycle.
    cfg_win_len = 8'd0;
    to_next_window();
    to_next_window();
    send(0, 0, 8); #1;
    chk("R3 one-cycle window sets", int'(throttle[0]), 1);
    @(negedge clk); #1;
    chk("R3 one-cycle window releases", int'(throttle[0]), 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule